// File: doc/BRIEF.md
# Serial Flash Program and Erase Sequencer

This block lets on-chip logic program a four-wire serial configuration flash without any knowledge of the flash's command set. A user asks for either a page write or a whole-chip erase through a valid/ready command port. A write carries a 24-bit start address and a byte count of 1 to 256, and the data bytes then arrive on a second valid/ready port. The sequencer produces every chip-select, serial-clock and data transition on the flash pins itself.

Every operation runs as a fixed chain of frames, each with its own chip-select pulse. The first frame carries only the write-enable opcode. The second frame carries the command: a write opcode with its address and data, or the erase opcode alone. Raising chip select at the end of that frame starts the flash's self-timed cycle. After it, read-status frames repeat until the busy bit of the status byte reads 0. The block then pulses a done strobe with a status flag, and only after that does it accept another command. A per-command option sends the data bytes least-significant bit first, for raw bitstream images.

A timeout counter starts when the command frame ends. If the flash still reports busy once the counter has reached the limit for that kind of operation, the operation ends with an error.

Top module: `sfp_prog_seq`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, `op_done_o` and `data_ready_o` are low, and `cmd_ready_o` is high within 2*HALF_DIV cycles.
- R2: Every write or erase begins with a frame that holds exactly one byte, the write-enable opcode (default 0x06).
- R3: A write's command frame is one chip-select pulse that carries the write opcode (default 0x02), then address bits 23..16, 15..8 and 7..0, each most-significant bit first, then `cmd_len_m1_i`+1 data bytes (1 to 256) in arrival order.
- R4: An erase's command frame carries the single byte 0xC7, most-significant bit first. Chip select rises with no serial clock edge after the eighth rising edge.
- R5: Serial data out changes only while the serial clock is low, and input data is sampled on the rising edge. Each clock high phase lasts HALF_DIV system cycles, and the clock is low whenever chip select is high.
- R6: Between any two frames, chip select stays high for at least 2*HALF_DIV system cycles.
- R7: After the command frame, the block sends read-status frames. Each one is the opcode (default 0x05) followed by a dummy byte 0x00, during which the status byte is read with the busy flag in bit 0. The frames repeat while that bit is 1. Once it reads 0, `op_done_o` pulses with `op_err_o` low.
- R8: When `cmd_lsb_first_i` is 1 at command acceptance, each data byte is sent bit 0 first. Opcodes and address bytes are still sent most-significant bit first.
- R9: The timeout counter measures system cycles from the end of the command frame. The limit is WR_TMO_CYC for a write and ER_TMO_CYC for an erase. A status poll that ends with the busy bit 1 after the limit is reached ends the operation with `op_done_o` and `op_err_o` both high, and no frame follows. A poll that ends with the busy bit 0 ends it without error even when the limit has already passed.
- R10: `data_ready_o` is high only while chip select is low in a write's data phase and the next byte is due. While no byte is offered, the serial clock stops with chip select held low, and the frame continues unchanged when the byte arrives.
- R11: `cmd_ready_o` stays low from acceptance until the end gap after `op_done_o`. A `cmd_valid_i` raised during that time has no effect on the flash pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request valid |
| cmd_ready_o | output | 1 | Command accepted when both valid and ready are high |
| cmd_erase_i | input | 1 | 1: whole-chip erase, 0: page write |
| cmd_addr_i | input | 24 | Write start address |
| cmd_len_m1_i | input | 8 | Number of write data bytes minus one |
| cmd_lsb_first_i | input | 1 | Send data bytes bit 0 first |
| data_valid_i | input | 1 | Write data byte valid |
| data_ready_o | output | 1 | Write data byte taken when both valid and ready are high |
| data_i | input | 8 | Write data byte |
| op_done_o | output | 1 | One-cycle pulse when the operation ends |
| op_err_o | output | 1 | With op_done_o: busy-wait timed out |
| flash_cs_n_o | output | 1 | Flash chip select, active low |
| flash_sclk_o | output | 1 | Flash serial clock |
| flash_mosi_o | output | 1 | Serial data to the flash |
| flash_miso_i | input | 1 | Serial data from the flash |

## Verification
The busy-wait has two exits that meet in a single decision at the end of a status poll: a clear busy flag and an expired timeout counter. The bench sets the write timeout to one cycle, so the counter has always expired by the time the first poll completes. The flash model then returns a clear flag on that first poll, which must be judged a success, or a set flag, which must give an error after exactly one poll with no later frame. An erase with several busy polls under its longer limit confirms that the limit follows the operation type.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WREN,
    ST_WREN_GAP,
    ST_CMD,
    ST_CMD_GAP,
    ST_POLL,
    ST_POLL_GAP,
    ST_END_GAP
  } sfp_state_e;

  // Reverse bit order of one byte.
  function automatic logic [7:0] sfp_rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  // Index of the final byte in the command frame.
  function automatic logic [8:0] sfp_cmd_last(input logic erase, input logic [7:0] len_m1);
    return erase ? 9'd0 : (9'd4 + {1'b0, len_m1});
  endfunction

  // Address byte sent at frame position 1..3, high byte first.
  function automatic logic [7:0] sfp_addr_byte(input logic [23:0] addr, input logic [1:0] pos);
    case (pos)
      2'd1:    return addr[23:16];
      2'd2:    return addr[15:8];
      default: return addr[7:0];
    endcase
  endfunction

endpackage

// File: rtl/sfp_cycle_timer.sv
module sfp_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         reached_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (cnt_q != {W{1'b1}}) cnt_q <= cnt_q + 1'b1;
  end

  assign reached_o = (cnt_q >= limit_i);

  // R9
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reached_o && !clr_i) |=> (reached_o || !$stable(limit_i)));

endmodule

// File: rtl/sfp_byte_shifter.sv
module sfp_byte_shifter import sfp_pkg::*; #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       lsb_first_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_o,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic [DW-1:0] div_q;
  logic [2:0]    bit_q;
  logic [7:0]    sreg_q;
  logic [7:0]    load_byte;
  logic          tick;

  assign load_byte = lsb_first_i ? sfp_rev8(tx_i) : tx_i;
  assign tick      = busy_o && (div_q == DIV_LAST);
  assign done_o    = tick && sclk_o && (bit_q == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      sclk_o <= 1'b0;
      mosi_o <= 1'b0;
      sreg_q <= '0;
      rx_o   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      sreg_q <= load_byte;
      mosi_o <= load_byte[7];
      bit_q  <= '0;
      div_q  <= '0;
      sclk_o <= 1'b0;
    end else if (busy_o) begin
      if (tick) begin
        div_q <= '0;
        if (!sclk_o) begin
          sclk_o <= 1'b1;
          rx_o   <= {rx_o[6:0], miso_i};
        end else begin
          sclk_o <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_o <= 1'b0;
          end else begin
            bit_q  <= bit_q + 1'b1;
            mosi_o <= sreg_q[6];
            sreg_q <= {sreg_q[6:0], 1'b0};
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R5
  mosi_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_o) |-> !sclk_o);

  // R5
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_o);

endmodule

// File: rtl/sfp_prog_seq.sv
module sfp_prog_seq import sfp_pkg::*; #(
  parameter int          HALF_DIV   = 4,
  parameter logic [7:0]  WREN_OP    = 8'h06,
  parameter logic [7:0]  RDSR_OP    = 8'h05,
  parameter logic [7:0]  PROG_OP    = 8'h02,
  parameter logic [7:0]  ERASE_OP   = 8'hC7,
  parameter int          TMO_W      = 32,
  parameter logic [31:0] WR_TMO_CYC = 32'd2_000_000,
  parameter logic [31:0] ER_TMO_CYC = 32'd400_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid_i,
  output logic        cmd_ready_o,
  input  logic        cmd_erase_i,
  input  logic [23:0] cmd_addr_i,
  input  logic [7:0]  cmd_len_m1_i,
  input  logic        cmd_lsb_first_i,
  input  logic        data_valid_i,
  output logic        data_ready_o,
  input  logic [7:0]  data_i,
  output logic        op_done_o,
  output logic        op_err_o,
  output logic        flash_cs_n_o,
  output logic        flash_sclk_o,
  output logic        flash_mosi_o,
  input  logic        flash_miso_i
);
  localparam int GAP_CYC = 2 * HALF_DIV;
  localparam int GW      = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] GAP_LIM = GW'(GAP_CYC - 1);

  sfp_state_e  state_q;
  logic        erase_q, lsb_q;
  logic [23:0] addr_q;
  logic [7:0]  len_m1_q;
  logic [8:0]  idx_q, frame_last;
  logic        cs_n_q;

  logic        in_frame, need_data, sh_start, sh_busy, sh_done, sh_lsb;
  logic [7:0]  sh_tx, sh_rx;
  logic        gap_reached, tmo_expired;
  logic [TMO_W-1:0] tmo_limit;

  // Named events
  logic frame_end, cmd_accept, poll_clear, poll_timeout;

  assign in_frame  = (state_q == ST_WREN) || (state_q == ST_CMD) || (state_q == ST_POLL);
  assign need_data = (state_q == ST_CMD) && !erase_q && (idx_q >= 9'd4);
  assign sh_start  = in_frame && !sh_busy && (!need_data || data_valid_i);
  assign sh_lsb    = need_data && lsb_q;

  assign data_ready_o = need_data && !sh_busy;
  assign cmd_ready_o  = (state_q == ST_IDLE) && gap_reached;
  assign cmd_accept   = cmd_valid_i && cmd_ready_o;
  assign flash_cs_n_o = cs_n_q;

  always_comb begin
    case (state_q)
      ST_CMD:  frame_last = sfp_cmd_last(erase_q, len_m1_q);
      ST_POLL: frame_last = 9'd1;
      default: frame_last = 9'd0;
    endcase
  end

  always_comb begin
    sh_tx = 8'h00;
    case (state_q)
      ST_WREN: sh_tx = WREN_OP;
      ST_CMD: begin
        if (idx_q == 9'd0)      sh_tx = erase_q ? ERASE_OP : PROG_OP;
        else if (idx_q < 9'd4)  sh_tx = sfp_addr_byte(addr_q, idx_q[1:0]);
        else                    sh_tx = data_i;
      end
      ST_POLL: sh_tx = (idx_q == 9'd0) ? RDSR_OP : 8'h00;
      default: sh_tx = 8'h00;
    endcase
  end

  assign frame_end    = sh_done && (idx_q == frame_last);
  assign poll_clear   = frame_end && (state_q == ST_POLL) && !sh_rx[0];
  assign poll_timeout = frame_end && (state_q == ST_POLL) && sh_rx[0] && tmo_expired;
  assign tmo_limit    = erase_q ? TMO_W'(ER_TMO_CYC) : TMO_W'(WR_TMO_CYC);

  sfp_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (sh_start),
    .tx_i       (sh_tx),
    .lsb_first_i(sh_lsb),
    .busy_o     (sh_busy),
    .done_o     (sh_done),
    .rx_o       (sh_rx),
    .sclk_o     (flash_sclk_o),
    .mosi_o     (flash_mosi_o),
    .miso_i     (flash_miso_i)
  );

  sfp_cycle_timer #(.W(GW)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (!cs_n_q),
    .limit_i  (GAP_LIM),
    .reached_o(gap_reached)
  );

  sfp_cycle_timer #(.W(TMO_W)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (state_q == ST_CMD),
    .limit_i  (tmo_limit),
    .reached_o(tmo_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      erase_q   <= 1'b0;
      lsb_q     <= 1'b0;
      addr_q    <= '0;
      len_m1_q  <= '0;
      idx_q     <= '0;
      cs_n_q    <= 1'b1;
      op_done_o <= 1'b0;
      op_err_o  <= 1'b0;
    end else begin
      op_done_o <= 1'b0;
      op_err_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (cmd_accept) begin
            erase_q  <= cmd_erase_i;
            lsb_q    <= cmd_lsb_first_i;
            addr_q   <= cmd_addr_i;
            len_m1_q <= cmd_len_m1_i;
            idx_q    <= '0;
            cs_n_q   <= 1'b0;
            state_q  <= ST_WREN;
          end
        end
        ST_WREN, ST_CMD, ST_POLL: begin
          if (frame_end) begin
            cs_n_q <= 1'b1;
            idx_q  <= '0;
            if (state_q == ST_WREN)     state_q <= ST_WREN_GAP;
            else if (state_q == ST_CMD) state_q <= ST_CMD_GAP;
            else if (poll_clear || poll_timeout) begin
              op_done_o <= 1'b1;
              op_err_o  <= poll_timeout;
              state_q   <= ST_END_GAP;
            end else                    state_q <= ST_POLL_GAP;
          end else if (sh_done) begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_WREN_GAP: if (gap_reached) begin cs_n_q <= 1'b0; state_q <= ST_CMD;  end
        ST_CMD_GAP:  if (gap_reached) begin cs_n_q <= 1'b0; state_q <= ST_POLL; end
        ST_POLL_GAP: if (gap_reached) begin cs_n_q <= 1'b0; state_q <= ST_POLL; end
        ST_END_GAP:  if (gap_reached) state_q <= ST_IDLE;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n_o |-> !flash_sclk_o);

  // R4
  byte_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_cs_n_o) |-> $past(sh_done));

  // R6
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_cs_n_o) |-> $past(gap_reached));

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_err_o |-> op_done_o);

  // R10
  data_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready_o |-> !flash_cs_n_o);

  // R11
  no_accept_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_cs_n_o |-> !cmd_ready_o);

  // R7
  done_outside_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done_o |-> (flash_cs_n_o && $rose(flash_cs_n_o)));

endmodule

// File: tb/test_sfp_prog_seq.sv
module test_sfp_prog_seq;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_erase = 1'b0, cmd_lsb = 1'b0;
  logic [23:0] cmd_addr = '0;
  logic [7:0]  cmd_len_m1 = '0;
  logic data_valid = 1'b0;
  logic [7:0] data = '0;
  logic miso = 1'b0;
  logic cmd_ready, data_ready, op_done, op_err, cs_n, sclk, mosi;

  always #2.5 clk = ~clk;

  sfp_prog_seq #(
    .HALF_DIV(HALF), .WR_TMO_CYC(32'd1), .ER_TMO_CYC(32'd5000)
  ) i_sfp_prog_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_erase_i(cmd_erase),
    .cmd_addr_i(cmd_addr), .cmd_len_m1_i(cmd_len_m1), .cmd_lsb_first_i(cmd_lsb),
    .data_valid_i(data_valid), .data_ready_o(data_ready), .data_i(data),
    .op_done_o(op_done), .op_err_o(op_err),
    .flash_cs_n_o(cs_n), .flash_sclk_o(sclk), .flash_mosi_o(mosi), .flash_miso_i(miso)
  );

  int checks = 0, fails = 0;

  // Scoreboard queues
  int          exp_len[$];
  logic [7:0]  exp_byte[$];
  string       exp_tag[$];
  logic        exp_err[$];
  string       exp_err_tag[$];

  // Flash model state
  logic wel = 1'b0;
  int   wip_left = 0;
  int   busy_cfg = 0;
  logic [7:0] status = '0;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [7:0] gen_byte(input logic [23:0] a, input int i);
    return 8'(a[7:0] + 8'(i * 7) + 8'h3c);
  endfunction

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic push_frame(input string tag, input logic [7:0] b[$]);
    exp_len.push_back(b.size());
    exp_tag.push_back(tag);
    foreach (b[i]) exp_byte.push_back(b[i]);
  endtask

  task automatic push_polls(input int n);
    for (int k = 0; k < n; k++) push_frame("R7", '{8'h05, 8'h00});
  endtask

  // Monitor
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_mosi = 1'b0;
  logic [7:0] cur = '0;
  logic [7:0] frm_q[$];
  int frm_bits = 0, gap_cnt = 0, hi_cnt = 0;
  int bad_mosi = 0, bad_hi = 0, bad_idle = 0, frames_seen = 0;
  bit first_frame = 1'b1;

  task automatic finish_frame();
    int n;
    bit ok;
    string tag;
    frames_seen++;
    if (exp_len.size() == 0) begin
      check(1'b0, "R11", "unexpected frame bytes", frm_q.size(), 0);
    end else begin
      n = exp_len.pop_front();
      tag = exp_tag.pop_front();
      ok = (frm_bits == 8 * n) && (frm_q.size() == n);
      for (int i = 0; i < n; i++) begin
        logic [7:0] e;
        e = exp_byte.pop_front();
        if (i < frm_q.size() && frm_q[i] != e) begin
          ok = 1'b0;
          $display("  byte %0d: actual %02h expected %02h", i, frm_q[i], e);
        end
      end
      check(ok, tag, "frame bits", frm_bits, 8 * n);
    end
    // Model reaction to the frame
    if (frm_bits == 8 && frm_q[0] == 8'h06) wel = 1'b1;
    else if (frm_bits == 8 && frm_q[0] == 8'hC7 && wel) begin wel = 1'b0; wip_left = busy_cfg; end
    else if (frm_bits >= 40 && frm_q[0] == 8'h02 && wel) begin wel = 1'b0; wip_left = busy_cfg; end
    else if (frm_bits == 16 && frm_q[0] == 8'h05 && wip_left > 0) wip_left--;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        if (!first_frame) check(gap_cnt >= 2 * HALF, "R6", "cs high gap", gap_cnt, 2 * HALF);
        first_frame = 1'b0;
        frm_bits = 0;
        frm_q.delete();
        status = {6'b0, wel, (wip_left > 0)};
        miso = 1'b0;
      end else if (!prev_cs && cs_n) begin
        finish_frame();
        gap_cnt = 0;
      end
      if (cs_n) begin
        gap_cnt++;
        if (sclk) bad_idle++;
      end else begin
        if (!prev_sclk && sclk) begin
          cur = {cur[6:0], mosi};
          frm_bits++;
          if (frm_bits % 8 == 0) frm_q.push_back(cur);
        end
        if (prev_sclk && !sclk) begin
          if (hi_cnt != HALF) bad_hi++;
          if (frm_q.size() > 0 && frm_q[0] == 8'h05 && frm_bits >= 8)
            miso = status[7 - (frm_bits % 8)];
        end
        if (sclk && prev_sclk && mosi != prev_mosi) bad_mosi++;
      end
      if (sclk) hi_cnt++; else hi_cnt = 0;
      if (op_done) begin
        if (exp_err.size() == 0) check(1'b0, "R7", "unexpected done", 1, 0);
        else begin
          logic e;
          string t;
          e = exp_err.pop_front();
          t = exp_err_tag.pop_front();
          check(op_err == e, t, "done error flag", int'(op_err), int'(e));
        end
      end
      prev_cs = cs_n;
      prev_sclk = sclk;
      prev_mosi = mosi;
    end
  end

  task automatic send_cmd(input bit erase, input logic [23:0] a, input int n, input bit lsb);
    @(negedge clk);
    cmd_erase = erase;
    cmd_addr = a;
    cmd_len_m1 = 8'(n - 1);
    cmd_lsb = lsb;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!op_done) @(negedge clk);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic do_write(input logic [23:0] a, input int n, input bit lsb, input int dly,
                          input int busy, input bit err, input string tag);
    logic [7:0] f[$];
    push_frame("R2", '{8'h06});
    f = '{8'h02, a[23:16], a[15:8], a[7:0]};
    for (int i = 0; i < n; i++) f.push_back(lsb ? rev8(gen_byte(a, i)) : gen_byte(a, i));
    push_frame(tag, f);
    push_polls(err ? 1 : busy + 1);
    exp_err.push_back(err);
    exp_err_tag.push_back(err ? "R9" : "R7");
    busy_cfg = busy;
    send_cmd(1'b0, a, n, lsb);
    for (int i = 0; i < n; i++) begin
      if (dly > 0) begin
        data_valid = 1'b0;
        repeat (dly) @(negedge clk);
      end
      data = gen_byte(a, i);
      data_valid = 1'b1;
      while (!data_ready) @(negedge clk);
      @(negedge clk);
    end
    data_valid = 1'b0;
    wait_done();
  endtask

  task automatic do_erase(input int busy, input bit poke);
    int bad;
    push_frame("R2", '{8'h06});
    push_frame("R4", '{8'hC7});
    push_polls(busy + 1);
    exp_err.push_back(1'b0);
    exp_err_tag.push_back("R7");
    busy_cfg = busy;
    send_cmd(1'b1, 24'h0, 1, 1'b0);
    if (poke) begin
      // R11: garbage command while busy
      bad = 0;
      repeat (20) @(negedge clk);
      cmd_erase = 1'b0;
      cmd_addr = 24'hABCDEF;
      cmd_valid = 1'b1;
      repeat (200) begin
        @(negedge clk);
        if (cmd_ready) bad++;
      end
      cmd_valid = 1'b0;
      check(bad == 0, "R11", "cmd_ready high while busy", bad, 0);
    end
    wait_done();
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int fs;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
    check(sclk == 1'b0, "R1", "sclk in reset", int'(sclk), 0);
    rst_n = 1'b1;
    repeat (2 * HALF + 2) @(negedge clk);
    check(cmd_ready == 1'b1, "R1", "cmd_ready after reset", int'(cmd_ready), 1);
    check(op_done == 1'b0 && data_ready == 1'b0, "R1", "done/data_ready idle",
          int'(op_done) + int'(data_ready), 0);

    // R3 single byte, R9 clear status wins over expired write limit
    do_write(24'h12_34_56, 1, 1'b0, 0, 0, 1'b0, "R3");
    // R3 several bytes, MSB first
    do_write(24'hA0_01_F0, 5, 1'b0, 0, 0, 1'b0, "R3");
    // R8 LSB-first data, address unchanged
    do_write(24'h80_40_C1, 4, 1'b1, 0, 0, 1'b0, "R8");
    // R10 stalled data stream
    do_write(24'h00_FF_02, 3, 1'b0, 13, 0, 1'b0, "R10");
    // R3 full 256-byte page
    do_write(24'h03_00_00, 256, 1'b0, 0, 0, 1'b0, "R3");
    // R9 write still busy at limit: error after one poll, no further frame
    do_write(24'h05_05_05, 2, 1'b0, 0, 2, 1'b1, "R3");
    fs = frames_seen;
    repeat (300) @(negedge clk);
    check(frames_seen == fs && cs_n, "R9", "frames after timeout", frames_seen - fs, 0);
    wip_left = 0;
    // R4 erase, R7 several busy polls, R9 longer erase limit, R11 ignored command
    do_erase(3, 1'b1);
    do_erase(0, 1'b0);

    repeat (50) @(negedge clk);
    check(exp_len.size() == 0, "R7", "frames outstanding", exp_len.size(), 0);
    check(exp_err.size() == 0, "R7", "done pulses outstanding", exp_err.size(), 0);
    check(bad_mosi == 0, "R5", "mosi change while sclk high", bad_mosi, 0);
    check(bad_hi == 0, "R5", "sclk high phase length", bad_hi, 0);
    check(bad_idle == 0, "R5", "sclk high while cs high", bad_idle, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule